// File: doc/BRIEF.md
# Bus Reset and Activity Detector

This block watches the two USB data lines and the PS/2 data line of a peripheral controller. A mode input chooses the condition under watch. In USB mode the condition is a single-ended zero, which means both USB lines are low. In PS/2 mode the condition is the PS/2 data line held low. A timer elsewhere supplies a one-cycle strobe about every 128 µs. The condition is sampled only on those strobes. Two consecutive true samples qualify an event, so a condition that lasts 256 µs is always caught. One that has lasted only a little over 128 µs can also be caught, depending on where it starts relative to the strobes.

While an event is qualified, the block holds a clear line to the device-address register. It also issues a one-cycle interrupt request when an enable input allows it. In USB mode the request comes when the reset condition ends. In PS/2 mode it comes as soon as the low level is qualified. Because the condition is only sampled on strobes, the end of an event can be seen up to one strobe interval late. The inputs are assumed to be synchronous to the clock already.

Top module: `bus_activity_detector`

## Requirements
- R1: With `modePs2` = 0, the condition is true exactly when `usbDp` = 0 and `usbDm` = 0. Any other line pair, and any level on `ps2Data`, makes it false.
- R2: With `modePs2` = 1, the condition is true exactly when `ps2Data` = 0. The USB lines have no effect in this mode.
- R3: Each clock edge with `tick` = 1 and the condition true adds one to a saturating run count that never exceeds 3. Each edge with `tick` = 1 and the condition false sets the count to 0. `addrClear` is 1 whenever the count is 2 or more, so it rises on the edge that samples the second consecutive true tick.
- R4: Once `addrClear` is 1, it stays 1 until the edge that samples the first tick with the condition false, and it falls on that edge.
- R5: With `modePs2` = 0, `irqPulse` is 1 for exactly the one cycle after the edge on which `addrClear` falls.
- R6: With `modePs2` = 1, `irqPulse` is 1 for exactly the one cycle after the edge on which `addrClear` rises.
- R7: `intEnable` is sampled on the edge that would raise the request. When it is 0 there, no pulse is issued, and `addrClear` behaves as it does with the enable set.
- R8: A qualified event produces at most one pulse, and a pulse never lasts longer than one cycle.
- R9: A clock edge with `rst` = 1 sets the run count to 0 and clears `addrClear` and `irqPulse`. A condition that was under way restarts from zero, and the reset edge raises no pulse.
- R10: Input activity on edges where `tick` = 0 has no effect on `addrClear` or `irqPulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe from the 128 µs timer |
| modePs2 | input | 1 | 1 selects PS/2 activity, 0 selects USB reset |
| intEnable | input | 1 | Interrupt request enable |
| usbDp | input | 1 | USB D+ line level |
| usbDm | input | 1 | USB D- line level |
| ps2Data | input | 1 | PS/2 data line level |
| addrClear | output | 1 | Holds the device-address register clear during an event |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
A wrong run count moves the rise or fall of `addrClear` by a whole tick interval. This shows at the port on the next tick edge after the fault. A wrong mode choice or wrong event edge makes `irqPulse` appear on the opposite edge of `addrClear`, or not at all. That is exposed within one event. The bench sweeps every 6-tick condition pattern in both modes, with the enable both on and off. It also toggles the inputs between ticks. It compares both outputs on every cycle against a count model built from the requirements, so a stale or extra state bit fails the check within a few cycles.

// File: rtl/busact_pkg.sv
package busact_pkg;
  typedef struct packed {
    logic countUp;
    logic countClr;
  } cnt_strobe_t;
endpackage

// File: rtl/busact_datapath.sv
module busact_datapath
  import busact_pkg::*;
#(
  parameter int CNT_W      = 2,
  parameter int QUAL_LEVEL = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        modePs2,
  input  logic        usbDp,
  input  logic        usbDm,
  input  logic        ps2Data,
  input  cnt_strobe_t strobe,
  output logic        condNow,
  output logic        qualified,
  output logic        qualifyNext
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] QUAL_AT  = CNT_W'(QUAL_LEVEL);
  localparam logic [CNT_W-1:0] PRE_QUAL = CNT_W'(QUAL_LEVEL - 1);

  logic [CNT_W-1:0] runCount;

  // Pick the watched line condition (R1, R2)
  always_comb condNow = modePs2 ? !ps2Data : (!usbDp && !usbDm);

  // Saturating run count of consecutive true tick samples (R3)
  always_ff @(posedge clk) begin
    if (rst)                                          runCount <= '0;
    else if (strobe.countClr)                         runCount <= '0;
    else if (strobe.countUp && runCount != CNT_MAX)   runCount <= runCount + 1'b1;
  end

  always_comb begin
    qualified   = (runCount >= QUAL_AT);
    qualifyNext = (runCount == PRE_QUAL);
  end

  assert_qualify_on_step_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.countUp && qualifyNext) |=> qualified);

  assert_false_tick_ends_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.countClr |=> !qualified);

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobe.countUp) && !$past(strobe.countClr)) |-> $stable(qualified));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> !qualified);
endmodule

// File: rtl/busact_control.sv
module busact_control
  import busact_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        modePs2,
  input  logic        intEnable,
  input  logic        condNow,
  input  logic        qualified,
  input  logic        qualifyNext,
  output cnt_strobe_t strobe,
  output logic        irqPulse
);
  logic fireNow;

  always_comb begin
    strobe.countUp  = tick && condNow;
    strobe.countClr = tick && !condNow;
    // PS/2: fire on the qualifying step; USB: fire when a qualified event ends
    fireNow = modePs2 ? (strobe.countUp && qualifyNext)
                      : (strobe.countClr && qualified);
  end

  always_ff @(posedge clk) begin
    if (rst) irqPulse <= 1'b0;
    else     irqPulse <= fireNow && intEnable;
  end

  assert_usb_on_end_R5: assert property (@(posedge clk) disable iff (rst)
    (irqPulse && !$past(modePs2)) |-> $fell(qualified));

  assert_ps2_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    (irqPulse && $past(modePs2)) |-> $rose(qualified));

  assert_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> $past(intEnable));

  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> !irqPulse);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> !irqPulse);
endmodule

// File: rtl/bus_activity_detector.sv
module bus_activity_detector
  import busact_pkg::*;
#(
  parameter int CNT_W      = 2,
  parameter int QUAL_LEVEL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic modePs2,
  input  logic intEnable,
  input  logic usbDp,
  input  logic usbDm,
  input  logic ps2Data,
  output logic addrClear,
  output logic irqPulse
);
  cnt_strobe_t strobe;
  logic condNow, qualified, qualifyNext;

  busact_datapath #(.CNT_W(CNT_W), .QUAL_LEVEL(QUAL_LEVEL)) u_datapath (
    .clk(clk), .rst(rst), .modePs2(modePs2), .usbDp(usbDp), .usbDm(usbDm),
    .ps2Data(ps2Data), .strobe(strobe), .condNow(condNow),
    .qualified(qualified), .qualifyNext(qualifyNext)
  );

  busact_control u_control (
    .clk(clk), .rst(rst), .tick(tick), .modePs2(modePs2), .intEnable(intEnable),
    .condNow(condNow), .qualified(qualified), .qualifyNext(qualifyNext),
    .strobe(strobe), .irqPulse(irqPulse)
  );

  assign addrClear = qualified;
endmodule

// File: tb/bus_activity_detector_bench.sv
module bus_activity_detector_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, modePs2 = 1'b0, intEnable = 1'b0;
  logic usbDp = 1'b1, usbDm = 1'b0, ps2Data = 1'b1;
  logic addrClear, irqPulse;

  int compared = 0, mismatched = 0;
  int expCnt = 0;
  logic expClr = 1'b0, expIrq = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  bus_activity_detector u_bus_activity_detector (
    .clk(clk), .rst(rst), .tick(tick), .modePs2(modePs2), .intEnable(intEnable),
    .usbDp(usbDp), .usbDm(usbDm), .ps2Data(ps2Data),
    .addrClear(addrClear), .irqPulse(irqPulse)
  );

  task automatic check(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // Line levels for a wanted condition; variant spreads the "false" encodings (R1, R2)
  task automatic setLines(logic m, logic condTrue, int variant);
    if (!m) begin
      ps2Data = variant[0];                 // ignored in USB mode (R1)
      if (condTrue) begin usbDp = 1'b0; usbDm = 1'b0; end
      else case (variant % 3)
        0: begin usbDp = 1'b1; usbDm = 1'b0; end
        1: begin usbDp = 1'b0; usbDm = 1'b1; end
        default: begin usbDp = 1'b1; usbDm = 1'b1; end
      endcase
    end else begin
      ps2Data = !condTrue;
      usbDp = condTrue ? variant[0] : 1'b0;  // SE0 ignored in PS/2 mode (R2)
      usbDm = condTrue ? variant[1] : 1'b0;
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare 1 ns later
  task automatic step(logic r, logic t, logic m, logic e, logic condTrue, int variant);
    logic c;
    logic fire;
    int nc;
    @(negedge clk);
    rst = r; tick = t; modePs2 = m; intEnable = e;
    setLines(m, condTrue, variant);
    @(posedge clk);
    c = condTrue;
    fire = 1'b0;
    nc = expCnt;
    if (r) nc = 0;
    else if (t) begin
      if (c) begin
        nc = (expCnt == 3) ? 3 : expCnt + 1;
        fire = m && expCnt == 1;
      end else begin
        nc = 0;
        fire = !m && expCnt >= 2;
      end
    end
    expIrq = fire && e && !r;
    expCnt = nc;
    expClr = (expCnt >= 2);
    #1;
    check(r ? "R9 addrClear" : (t ? "R4 addrClear" : "R10 addrClear"), addrClear, expClr);
    if (r)          check("R9 irqPulse", irqPulse, expIrq);
    else if (!e)    check("R7 irqPulse", irqPulse, expIrq);
    else if (m)     check("R6 irqPulse R8", irqPulse, expIrq);
    else            check("R5 irqPulse R8", irqPulse, expIrq);
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // Reset state (R9)
    step(1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 1);

    // Sweep all 6-tick patterns, both modes, enable on and off (R1..R8, R10)
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int pat = 0; pat < 64; pat++) begin
          for (int k = 0; k < 6; k++) begin
            step(0, 1, m[0], e[0], pat[k], pat + k);
            for (int g = 0; g < (k + pat) % 3; g++)
              step(0, 0, m[0], e[0], !pat[k], g + k);   // glitches between ticks (R10)
          end
          for (int f = 0; f < 2; f++) step(0, 1, m[0], e[0], 0, f);
        end

    // Enable sampled only at the firing edge (R7)
    for (int m = 0; m < 2; m++) begin
      step(0, 1, m[0], 0, 1, 0);
      step(0, 1, m[0], 0, 1, 1);
      step(0, 1, m[0], 1, 1, 2);
      step(0, 1, m[0], 1, 0, 0);
      step(0, 0, m[0], 1, 0, 1);
    end

    // Reset in the middle of a qualified event restarts it (R9)
    for (int m = 0; m < 2; m++) begin
      step(0, 1, m[0], 1, 1, 0);
      step(0, 1, m[0], 1, 1, 1);
      step(1, 1, m[0], 1, 0, 0);
      step(0, 1, m[0], 1, 1, 0);
      step(0, 1, m[0], 1, 1, 1);
      step(0, 1, m[0], 1, 0, 2);
      step(0, 0, m[0], 1, 0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule